// File: doc/BRIEF.md
# Cartridge Bank-Select Latch

This block holds one 8-bit register that a game console CPU writes through the upper half of its address space. The register steers the high address lines of the cartridge's program ROM and graphics RAM, and it picks the nametable for single-screen mirroring. The program space splits into two 16 KB windows. The lower window, 0x8000–0xBFFF, shows whichever bank the register selects. The upper window, 0xC000–0xFFFF, always shows the last bank of the ROM.

Static straps describe the board. They give the ROM size as a power-of-two bank count, the size of the graphics RAM, and whether the program memory is a flash part. Without flash, the latch models a bus conflict: the byte the CPU writes collides with the byte the ROM drives at the same address. When flash is fitted, writes to the lower window go to a separate flash command path. A one-cycle strobe marks those writes, and the latch ignores them.

Top module: `cart_bank_latch`

## Requirements
- R1: After reset the latch holds 0x00. The lower window then maps to bank 0, the graphics bank is 0 and nametable A is selected.
- R2: For a CPU address with bit 14 clear, `rom_bank_addr` equals latch bits 4:0 ANDed with (2^`rom_banks_log2` − 1). A strap value above 5 counts as 5.
- R3: For a CPU address with bit 14 set, `rom_bank_addr` equals (2^`rom_banks_log2` − 1), which is the last bank, whatever the latch holds.
- R4: `chr_bank_addr` is derived from latch bits 6:5 and the `chr_ram_size` strap:
  - size code 0 (8 KB) gives 0.
  - size code 1 (16 KB) gives {0, latch bit 5}.
  - size codes 2 and 3 (32 KB) give latch bits 6:5.
- R5: `nt_screen_b` equals latch bit 7. A value of 1 selects screen B.
- R6: With `flash_en` low, a write to 0x8000–0xFFFF whose data equals `rom_q` loads that data into the latch.
- R7: With `flash_en` low, a write to 0x8000–0xFFFF whose data differs from `rom_q` loads 0x00 into the latch.
- R8: With `flash_en` high, a write to 0xC000–0xFFFF loads the data into the latch, whatever `rom_q` holds.
- R9: With `flash_en` high, a write to 0x8000–0xBFFF leaves the latch unchanged. During that write's cycle `flash_cmd_wr` is 1; at all other times it is 0.
- R10: The latch stays unchanged when the CPU address is below 0x8000 or when `cpu_wr` is 0.
- R11: The latch updates on the rising clock edge that samples a qualified write. Before that edge, the outputs still reflect the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| rom_q | input | 8 | Byte driven by the program ROM at `cpu_addr` |
| rom_banks_log2 | input | 3 | log2 of the number of 16 KB ROM banks (0..5) |
| chr_ram_size | input | 2 | Graphics RAM size: 0 = 8 KB, 1 = 16 KB, 2 or 3 = 32 KB |
| flash_en | input | 1 | Flash fitted; disables bus-conflict modelling |
| rom_bank_addr | output | 5 | Program ROM address bits 18:14 |
| chr_bank_addr | output | 2 | Graphics RAM address bits 14:13 |
| nt_screen_b | output | 1 | Single-screen nametable select |
| flash_cmd_wr | output | 1 | Lower-window write forwarded to the flash command path |

## Verification
The embedded assertions check every latch update on every cycle:
- the bus-conflict outcomes for matching and mismatching data;
- the unconditional load in flash mode;
- the latch holding through lower-window flash writes;
- the latch holding through writes outside the cartridge space or without a strobe.

Only the bench's scenarios and its cycle-by-cycle model can show the output mapping: the bank masking for each ROM size, the fixed last bank, the graphics-RAM size masking and the nametable bit. The same applies to R1 and to the fact that outputs lag a write by exactly one edge.

// File: rtl/cart_bank_latch.sv
module cart_bank_latch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BANK_W = 5,
  parameter int CHR_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [DATA_W-1:0]         cpu_data,
  input  logic                      cpu_wr,
  input  logic [DATA_W-1:0]         rom_q,
  input  logic [2:0]                rom_banks_log2,
  input  logic [1:0]                chr_ram_size,
  input  logic                      flash_en,
  output logic [BANK_W-1:0]         rom_bank_addr,
  output logic [CHR_W-1:0]          chr_bank_addr,
  output logic                      nt_screen_b,
  output logic                      flash_cmd_wr
);
  localparam int CHR_LSB = 5;
  localparam int NT_BIT  = DATA_W - 1;

  logic [DATA_W-1:0] latch_q;
  logic [BANK_W-1:0] bank_mask;
  logic [CHR_W-1:0]  chr_mask;

  wire in_cart   = cpu_addr[ADDR_W-1];
  wire hi_window = cpu_addr[ADDR_W-2];
  wire wr_cart   = cpu_wr && in_cart;
  wire load_en   = wr_cart && (!flash_en || hi_window);
  wire [DATA_W-1:0] load_val = (flash_en || cpu_data == rom_q) ? cpu_data : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       latch_q <= '0;
    else if (load_en) latch_q <= load_val;

  always_comb begin
    bank_mask = '0;
    for (int i = 0; i < BANK_W; i++)
      if (i < int'(rom_banks_log2)) bank_mask[i] = 1'b1;
  end

  always_comb
    case (chr_ram_size)
      2'd0:    chr_mask = '0;
      2'd1:    chr_mask = CHR_W'(1);
      default: chr_mask = '1;
    endcase

  assign rom_bank_addr = hi_window ? bank_mask : (latch_q[BANK_W-1:0] & bank_mask);
  assign chr_bank_addr = latch_q[CHR_LSB +: CHR_W] & chr_mask;
  assign nt_screen_b   = latch_q[NT_BIT];
  assign flash_cmd_wr  = wr_cart && flash_en && !hi_window;

  AST_CONFLICT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && in_cart && !flash_en && cpu_data == rom_q) |=> latch_q == $past(cpu_data)); // R6
  AST_CONFLICT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && in_cart && !flash_en && cpu_data != rom_q) |=> latch_q == '0); // R7
  AST_FLASH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && in_cart && hi_window && flash_en) |=> latch_q == $past(cpu_data)); // R8
  AST_FLASH_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_cmd_wr) |=> $stable(latch_q)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr || !in_cart) |=> $stable(latch_q)); // R10
endmodule

// File: tb/sim_cart_bank_latch.sv
`timescale 1ns/1ps
module sim_cart_bank_latch;
  logic        clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 0, rom_q = 0;
  logic        cpu_wr = 0;
  logic [2:0]  rom_banks_log2 = 3'd5;
  logic [1:0]  chr_ram_size = 2'd2;
  logic        flash_en = 0;
  logic [4:0]  rom_bank_addr;
  logic [1:0]  chr_bank_addr;
  logic        nt_screen_b, flash_cmd_wr;

  int total = 0, bad = 0;
  int ref_latch = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cart_bank_latch u0 (.*);

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ref_latch <= 0;
    else if (cpu_wr && cpu_addr[15]) begin
      if (!flash_en) ref_latch <= (cpu_data == rom_q) ? cpu_data : 0;
      else if (cpu_addr[14]) ref_latch <= cpu_data;
    end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_bank();
    int lg = (rom_banks_log2 > 5) ? 5 : rom_banks_log2;
    int m  = (1 << lg) - 1;
    return cpu_addr[14] ? m : (ref_latch & m);
  endfunction

  function automatic int exp_chr();
    case (chr_ram_size)
      2'd0: return 0;
      2'd1: return (ref_latch >> 5) & 1;
      default: return (ref_latch >> 5) & 3;
    endcase
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    #2;
    chk(cpu_addr[14] ? "R3 model" : "R2 model", rom_bank_addr, exp_bank());
    chk("R4 model", chr_bank_addr, exp_chr());
    chk("R5 model", nt_screen_b, (ref_latch >> 7) & 1);
    chk("R9 model", flash_cmd_wr, cpu_wr && flash_en && cpu_addr[15:14] == 2'b10);
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [7:0] q);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; rom_q = q; cpu_wr = 1;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic peek(input string req, input int exp);
    logic [2:0] sl = rom_banks_log2;
    logic [1:0] sc = chr_ram_size;
    logic [15:0] sa = cpu_addr;
    @(negedge clk);
    cpu_addr = 16'h8000; rom_banks_log2 = 5; chr_ram_size = 2;
    #3;
    chk(req, {nt_screen_b, chr_bank_addr, rom_bank_addr}, exp);
    rom_banks_log2 = sl; chr_ram_size = sc; cpu_addr = sa;
  endtask

  initial begin
    #10000000;
    total++; bad++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    peek("R1 reset", 8'h00);

    wr(16'hC123, 8'hA5, 8'hA5);
    peek("R6 match load", 8'hA5);
    @(negedge clk); cpu_addr = 16'hC000; #3;
    chk("R3 last bank", rom_bank_addr, 31);

    wr(16'h8456, 8'h3C, 8'h3D);
    peek("R7 conflict zero", 8'h00);

    wr(16'h9000, 8'h5A, 8'h5A);
    wr(16'h7FFF, 8'h77, 8'h77);
    peek("R10 below window", 8'h5A);
    @(negedge clk); cpu_addr = 16'hE000; cpu_data = 8'h11; rom_q = 8'h11; cpu_wr = 0;
    peek("R10 no strobe", 8'h5A);

    flash_en = 1;
    wr(16'hE000, 8'h9F, 8'h00);
    peek("R8 flash load", 8'h9F);
    @(negedge clk);
    cpu_addr = 16'h9555; cpu_data = 8'h12; rom_q = 8'h12; cpu_wr = 1;
    #3 chk("R9 cmd strobe", flash_cmd_wr, 1);
    @(negedge clk); cpu_wr = 0;
    #3 chk("R9 strobe off", flash_cmd_wr, 0);
    peek("R9 latch held", 8'h9F);

    wr(16'hF000, 8'hE7, 8'h00);
    @(negedge clk);
    cpu_addr = 16'h8000; rom_banks_log2 = 2; #3;
    chk("R2 mask 4 banks", rom_bank_addr, 3);
    rom_banks_log2 = 0; #1;
    chk("R2 mask 1 bank", rom_bank_addr, 0);
    rom_banks_log2 = 7; #1;
    chk("R2 clamp", rom_bank_addr, 7);
    cpu_addr = 16'hC000; rom_banks_log2 = 2; #1;
    chk("R3 last of 4", rom_bank_addr, 3);
    chr_ram_size = 0; #1; chk("R4 8K", chr_bank_addr, 0);
    chr_ram_size = 1; #1; chk("R4 16K", chr_bank_addr, 1);
    chr_ram_size = 3; #1; chk("R4 32K", chr_bank_addr, 3);
    chk("R5 screen B", nt_screen_b, 1);

    @(negedge clk);
    cpu_addr = 16'hC000; cpu_data = 8'h02; cpu_wr = 1; rom_banks_log2 = 5; chr_ram_size = 2;
    cpu_addr = 16'h8000; #3;
    chk("R11 before edge", rom_bank_addr, 7);
    cpu_addr = 16'hC000;
    @(negedge clk); cpu_wr = 0; cpu_addr = 16'h8000; #3;
    chk("R11 after edge", rom_bank_addr, 2);

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      cpu_addr = 16'($urandom);
      cpu_data = 8'($urandom);
      rom_q = ($urandom % 2) ? cpu_data : 8'($urandom);
      cpu_wr = 1'($urandom);
      flash_en = 1'($urandom);
      rom_banks_log2 = 3'($urandom % 6);
      chr_ram_size = 2'($urandom);
    end
    @(negedge clk); cpu_wr = 0;
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule